// File: doc/BRIEF.md
# Chip-Select Memory Bus Controller

This block turns single internal read or write requests into external bus cycles for one chip-select region. The region holds asynchronous FLASH or SRAM devices, or 8-bit peripherals, that have their own chip-select, output-enable and write-enable pins. The internal side presents an address, write data, byte enables and a direction flag with a request. It gets back read data and a one-clock completion pulse. The external side drives address, write data with its own output enable, a chip select, an output enable, a shared direction line and four active-low byte strobes. It also accepts an active-low acknowledge from outside.

Two configuration inputs shape each cycle. A 2-bit mode code chooses what the byte strobes mean. In code 2'b11 each strobe is a write pulse for one 8-bit SRAM lane, so it can drive that device's write input directly. Every other code, 2'b00 being the normal one, uses the strobes to mark the active lanes of both reads and writes, and the direction line qualifies them. A 5-bit wait field adds clocks to a cycle that ends internally. The all-ones value instead hands termination to the external acknowledge.

Top module: `csmem_ctrl`

## Requirements
- R1: While reset is held and in the first clock after it, mem_cs_n, mem_oe_n and all of mem_bs_n are 1, mem_wdata_oe and done are 0, and req_ready is 1.
- R2: A request is taken only at a rising edge where req and req_ready are both 1. req_ready is 1 only while the bus is idle. Address, data, byte enables, direction, cfg_mode and cfg_wait are all latched at that edge. A request raised while req_ready is 0 starts no cycle.
- R3: With a latched wait value W below 31, mem_cs_n stays 0 for exactly W+2 clocks, starting in the clock after acceptance.
- R4: With W = 31, the cycle ends at the first rising edge, from the second bus clock onward, at which mem_ta_n is sampled 0. mem_ta_n sampled 0 at the end of the first bus clock is ignored, so a cycle always lasts at least 2 clocks.
- R5: mem_oe_n is 0 in exactly the clocks where mem_cs_n is 0 during a read. It stays 1 throughout writes and while idle.
- R6: For mode codes 2'b00, 2'b01 and 2'b10, mem_bs_n equals the inverted latched byte enables whenever mem_cs_n is 0, on reads and writes alike. mem_rw is 1 for a read and 0 for a write.
- R7: For mode code 2'b11, mem_bs_n bit i is 0 only while mem_cs_n is 0 during a write whose byte enable bit i is 1. All strobes stay 1 during reads. mem_rw follows the same read/write levels as in R6.
- R8: mem_wdata_oe is 1 in exactly the clocks where mem_cs_n is 0 during a write, and mem_wdata then equals the latched write data.
- R9: mem_addr equals the latched request address and does not change while mem_cs_n is 0.
- R10: On a read, rdata takes the value of mem_rdata sampled at the terminating edge. done is 1 for exactly one clock, the clock in which mem_cs_n has just returned to 1.
- R11: After every cycle, mem_cs_n and all strobes stay 1 for at least one clock. req_ready returns to 1 in the clock after done.
- R12: While mem_cs_n is 1, all of mem_bs_n is 1 and mem_wdata_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Strobe mode code, latched at acceptance |
| cfg_wait | input | 5 | Wait clocks; all ones selects external acknowledge |
| req | input | 1 | Request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Request address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for byte lane i |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read data of the last read |
| mem_addr | output | 23 | External address |
| mem_wdata | output | 32 | External write data |
| mem_wdata_oe | output | 1 | Drive enable for the external data bus |
| mem_rdata | input | 32 | External read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rw | output | 1 | Direction line, 1 = read |
| mem_bs_n | output | 4 | Byte strobes, active low |
| mem_ta_n | input | 1 | External transfer acknowledge, active low |

## Verification
The bus signals change in the clock after the accepting edge. With internal termination, done is due W+2 clocks after that edge. With external termination, done is due in the clock after the edge that samples the acknowledge, counted from the second bus clock. req_ready returns one clock after done. The bench drives every input at a falling edge and samples at the next falling edge, once per bus clock. It counts the clocks in which chip select is low and compares that count with the expected length for the wait value or acknowledge delay it applied. It also checks done, rdata and req_ready at exactly the first and second falling edges after chip select rises.

// File: rtl/csmem_pkg.sv
package csmem_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RECOV} bus_state_t;

  localparam logic [1:0] MODE_BYTE_WE = 2'b11;

  // Wait code of all ones hands termination to the external acknowledge.
  function automatic logic wait_is_ext(input logic [4:0] ws);
    return &ws;
  endfunction

  // Value of the bus-clock counter at the terminating edge: W+1 (C1 is count 0).
  function automatic logic [5:0] last_count(input logic [4:0] ws);
    return {1'b0, ws} + 6'd1;
  endfunction

  // One lane strobe, active high: lane enabled and, in write-pulse mode, a write.
  function automatic logic lane_on(input logic active, input logic we_mode,
                                   input logic wr, input logic be_bit);
    return active && be_bit && (wr || !we_mode);
  endfunction
endpackage

// File: rtl/csmem_seq.sv
module csmem_seq
  import csmem_pkg::*;
#(
  parameter int WSW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           ext_term,
  input  logic [WSW:0]   last_cnt,
  input  logic           ta_n,
  output bus_state_t     state,
  output logic           term
);
  logic [WSW:0] cnt;
  logic         cnt_int_hit;
  logic         ta_hit;

  assign cnt_int_hit = (cnt == last_cnt);
  assign ta_hit      = (cnt != '0) && !ta_n;
  assign term        = (state == ST_BUS) && (ext_term ? ta_hit : cnt_int_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_BUS;
        end
        ST_BUS: begin
          if (term) begin
            state <= ST_RECOV;
            cnt   <= '0;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csmem_lanes.sv
module csmem_lanes
  import csmem_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             active,
  input  logic             we_mode,
  input  logic             wr,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] bs_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bs_n[i] = !lane_on(active, we_mode, wr, be[i]);
  end
endmodule

// File: rtl/csmem_ctrl.sv
module csmem_ctrl
  import csmem_pkg::*;
#(
  parameter int AW  = 23,
  parameter int DW  = 32,
  parameter int WSW = 5,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [WSW-1:0]   cfg_wait,
  input  logic             req,
  input  logic             req_wr,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_wdata_oe,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_rw,
  output logic [LANES-1:0] mem_bs_n,
  input  logic             mem_ta_n
);
  bus_state_t       state;
  logic             term;
  logic             start;
  logic             bus_active;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic             wr_q;
  logic [1:0]       mode_q;
  logic [WSW-1:0]   wait_q;
  logic [DW-1:0]    rdata_q;
  logic             done_q;

  // Named events for the checker
  logic             lat_ext;
  logic             lat_we_mode;
  logic [WSW:0]     lat_last;

  assign req_ready   = (state == ST_IDLE);
  assign start       = req && req_ready;
  assign bus_active  = (state == ST_BUS);
  assign lat_ext     = wait_is_ext(wait_q);
  assign lat_we_mode = (mode_q == MODE_BYTE_WE);
  assign lat_last    = last_count(wait_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      mode_q  <= '0;
      wait_q  <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      wr_q    <= req_wr;
      mode_q  <= cfg_mode;
      wait_q  <= cfg_wait;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= term;
      if (term && !wr_q) rdata_q <= mem_rdata;
    end
  end

  csmem_seq #(.WSW(WSW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ext_term (lat_ext),
    .last_cnt (lat_last),
    .ta_n     (mem_ta_n),
    .state    (state),
    .term     (term)
  );

  csmem_lanes #(.LANES(LANES)) u_lanes (
    .active  (bus_active),
    .we_mode (lat_we_mode),
    .wr      (wr_q),
    .be      (be_q),
    .bs_n    (mem_bs_n)
  );

  assign done         = done_q;
  assign rdata        = rdata_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign mem_wdata_oe = bus_active && wr_q;
  assign mem_cs_n     = !bus_active;
  assign mem_oe_n     = !(bus_active && !wr_q);
  assign mem_rw       = !wr_q;
endmodule

// File: rtl/csmem_chk.sv
module csmem_chk #(
  parameter int AW  = 23,
  parameter int WSW = 5,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             req_ready,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_wdata_oe,
  input logic             mem_cs_n,
  input logic             mem_oe_n,
  input logic             mem_rw,
  input logic [LANES-1:0] mem_bs_n,
  input logic             mem_ta_n,
  input logic             lat_ext,
  input logic             lat_we_mode,
  input logic [WSW:0]     lat_last
);
  logic [WSW+1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!mem_cs_n) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  assert_int_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs_n) && !lat_ext) |-> (low_run == {1'b0, lat_last} + 1'b1));

  assert_ext_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs_n) && lat_ext) |-> ($past(!mem_ta_n) && low_run >= 2));

  assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_rw));

  assert_we_mode_reads_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_we_mode && mem_rw) |-> (&mem_bs_n));

  assert_wdata_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wdata_oe |-> (!mem_cs_n && !mem_rw));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_done_with_cs_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(mem_cs_n));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_recovery_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (mem_cs_n && req_ready));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> ((&mem_bs_n) && !mem_wdata_oe));
endmodule

bind csmem_ctrl csmem_chk #(.AW(AW), .WSW(WSW), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done         (done),
  .req_ready    (req_ready),
  .mem_addr     (mem_addr),
  .mem_wdata_oe (mem_wdata_oe),
  .mem_cs_n     (mem_cs_n),
  .mem_oe_n     (mem_oe_n),
  .mem_rw       (mem_rw),
  .mem_bs_n     (mem_bs_n),
  .mem_ta_n     (mem_ta_n),
  .lat_ext      (lat_ext),
  .lat_we_mode  (lat_we_mode),
  .lat_last     (lat_last)
);

// File: tb/sim_csmem_ctrl.sv
module sim_csmem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic [4:0]  cfg_wait;
  logic        req, req_wr;
  logic [22:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic [22:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_wdata_oe;
  logic [31:0] mem_rdata;
  logic        mem_cs_n, mem_oe_n, mem_rw;
  logic [3:0]  mem_bs_n;
  logic        mem_ta_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Memory model: read data is a fixed function of the address
  assign mem_rdata = 32'hC3A5_0000 ^ {9'd0, mem_addr};

  csmem_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One transaction; td < 0 means internal termination
  task automatic run_txn(input logic [1:0] mode, input logic [4:0] ws, input bit wr,
                         input logic [3:0] be, input logic [22:0] addr,
                         input logic [31:0] wd, input int td);
    int n = 0;
    int exp_len;
    bit e_bs = 0, e_oe = 0, e_rw = 0, e_doe = 0, e_wd = 0, e_ad = 0;
    logic [3:0] exp_bs;
    logic [31:0] old_rdata;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    old_rdata = rdata;
    cfg_mode = mode; cfg_wait = ws; req_wr = wr; req_be = be;
    req_addr = addr; req_wdata = wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    cfg_mode = ~mode; cfg_wait = (ws == 5'h1F) ? 5'd0 : 5'h1F;
    req_addr = ~addr; req_wdata = ~wd; req_be = ~be; req_wr = ~wr;
    if (mode == 2'b11) exp_bs = wr ? ~be : 4'hF;
    else exp_bs = ~be;
    if (td < 0) exp_len = ws + 2;
    else exp_len = ((td < 1) ? 1 : td) + 1;
    while (!mem_cs_n && n < 100) begin
      if (mem_bs_n !== exp_bs) e_bs = 1;
      if (mem_oe_n !== wr) e_oe = 1;
      if (mem_rw !== !wr) e_rw = 1;
      if (mem_wdata_oe !== wr) e_doe = 1;
      if (wr && mem_wdata !== wd) e_wd = 1;
      if (mem_addr !== addr) e_ad = 1;
      if (td >= 0 && n >= td) mem_ta_n = 1'b0;
      n++;
      @(negedge clk);
    end
    mem_ta_n = 1'b1;
    if (td < 0) chk(n == exp_len, "R3 bus length", n, exp_len);
    else chk(n == exp_len, "R4 ack length", n, exp_len);
    chk(!e_bs, (mode == 2'b11) ? "R7 strobes" : "R6 strobes", mode, exp_bs);
    chk(!e_rw, "R6 R7 direction", wr, !wr);
    chk(!e_oe, "R5 output enable", wr, wr);
    chk(!e_doe && !e_wd, "R8 write drive", e_wd, 0);
    chk(!e_ad, "R9 address hold", 0, addr);
    chk(done === 1'b1 && req_ready === 1'b0, "R10 done pulse", done, 1);
    chk(rdata === (wr ? old_rdata : (32'hC3A5_0000 ^ {9'd0, addr})), "R10 read data",
        rdata, wr ? old_rdata : (32'hC3A5_0000 ^ {9'd0, addr}));
    chk(mem_cs_n === 1'b1 && mem_bs_n === 4'hF && mem_wdata_oe === 1'b0,
        "R12 idle quiet", mem_bs_n, 4'hF);
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1 && mem_cs_n === 1'b1, "R11 recovery",
        {done, req_ready, mem_cs_n}, 3'b011);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [4:0] wlist [4] = '{5'd0, 5'd1, 5'd3, 5'd30};
    logic [3:0] blist [4] = '{4'hF, 4'b0001, 4'b1010, 4'b0110};
    rst_n = 1'b0; req = 0; req_wr = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    cfg_mode = 0; cfg_wait = 0; mem_ta_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_bs_n == 4'hF && !mem_wdata_oe && !done && req_ready,
        "R1 reset outputs", {mem_cs_n, mem_oe_n, mem_bs_n}, 6'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n && !done && req_ready, "R1 after reset", {mem_cs_n, req_ready}, 2'b11);

    // Internal termination sweep: every mode, both directions, several waits
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++)
        for (int d = 0; d < 2; d++)
          run_txn(m[1:0], wlist[w], d[0], blist[(m + w + d) % 4],
                  23'h0A000 + 23'(m * 64 + w * 8 + d), 32'h1234_0000 + 32'(m * 16 + w), -1);

    // External acknowledge: delay 0 proves a first-clock acknowledge is ignored
    for (int m = 0; m < 2; m++)
      for (int t = 0; t < 3; t++)
        for (int d = 0; d < 2; d++)
          run_txn(m ? 2'b11 : 2'b00, 5'h1F, d[0], blist[t + 1],
                  23'h7F000 + 23'(t * 4 + d), 32'hBEEF_0000 + 32'(t), (t == 2) ? 5 : t);

    // R2: request while busy must not start a second cycle
    @(negedge clk);
    cfg_mode = 2'b00; cfg_wait = 5'd2; req_wr = 0; req_be = 4'hF; req_addr = 23'h111;
    req = 1'b1;
    @(negedge clk);
    req_addr = 23'h222;
    @(negedge clk);
    chk(!mem_cs_n && mem_addr == 23'h111 && !req_ready, "R2 busy ignore", mem_addr, 23'h111);
    req = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(mem_cs_n === 1'b1 && req_ready === 1'b1, "R2 no stray cycle", mem_cs_n, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule